// File: doc/BRIEF.md
# Memory Error Event Counter Bank

This block tallies error events that an ECC checker in a memory controller reports. Each event is marked as correctable (CE) or uncorrectable (UE). It can carry a location made of a channel index and a DIMM slot index. The controller has three channels with up to three slots each. Every event is counted in several places at the same time:

- an exact counter for its channel and slot;
- a coarse counter keyed only by slot number, which merges all channels;
- a controller-wide total for its error type.

An event that has no usable location goes to a separate "no location" counter of its type instead of any per-location or per-slot counter.

A seconds timer counts up from the last reset. It is driven by a parameterised prescaler of clock cycles per second. Software reads any counter or the timer through a registered read port. A single clear strobe zeroes every counter and restarts the timer. Two log-enable inputs decide whether an event also raises a one-cycle log request. Counting is the same whatever those inputs are.

Top module: `memerr_counter_bank`

## Requirements
- R1: Each of the 9 channel/slot locations has its own CE counter at read address 16+2*(chan*3+slot) and its own UE counter at the next address. A located event of a type increments exactly that location's counter of its type.
- R2: The CE total (address 0) and the UE total (address 1) increment on every accepted event of their type, whether it is located or not.
- R3: The slot counters at addresses 5+slot (CE) and 8+slot (UE) merge all channels. A located event on slot N of any channel increments counter N of its type.
- R4: A cycle with clr_strobe high zeroes every counter, the seconds value and the prescaler. An event presented in that same cycle is dropped.
- R5: An event is unlocated when ev_loc_ok is 0, when ev_chan is 3 or more, or when ev_slot is 3 or more. It increments only its type's no-location counter (address 2 for CE, 3 for UE) and its total, and no per-location or per-slot counter.
- R6: Counting does not depend on log_ce_en or log_ue_en. One cycle after an accepted event whose type is enabled, log_valid is 1 and log_ue gives its type (1 = UE). For a disabled type, log_valid stays 0.
- R7: Every counter saturates at 2^CNT_W-1 and does not wrap.
- R8: The seconds value (address 4) increments once every CYC_PER_SEC cycles after reset or clear, and saturates at 2^SEC_W-1.
- R9: rd_data returns, one clock after rd_addr is presented, the zero-extended value addressed. Unmapped addresses read as 0.
- R10: After reset, every counter and the seconds value read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Error event present this cycle |
| ev_ue | input | 1 | 1 = uncorrectable, 0 = correctable |
| ev_loc_ok | input | 1 | Event carries location information |
| ev_chan | input | 2 | Channel index |
| ev_slot | input | 2 | DIMM slot index |
| log_ce_en | input | 1 | Raise log requests for CE events |
| log_ue_en | input | 1 | Raise log requests for UE events |
| clr_strobe | input | 1 | Clear all counters and restart the timer |
| rd_addr | input | 6 | Read address |
| rd_data | output | max(CNT_W,SEC_W) | Registered read data |
| log_valid | output | 1 | Log request for the previous cycle's event |
| log_ue | output | 1 | Type of the logged event |

## Verification
A misrouted increment shows up as a wrong value on one read address. Examples are a located event landing in the no-location counter, or a slot counter that does not merge channels. That value is visible two cycles after the event, once a read is issued. Because the bench reads the whole map after a mixed event stream, one stray or missing increment appears as a mismatch between neighbouring counters. A prescaler that is off by one moves the seconds step by a cycle, which the reads taken on each side of the step reveal. A counter that wraps or a clear that leaks an event shows as a nonzero or small value where 0 or the maximum is expected.

// File: rtl/memerr_pkg.sv
package memerr_pkg;

    localparam int NUM_CHAN = 3;
    localparam int NUM_SLOT = 3;
    localparam int NUM_LOC  = NUM_CHAN * NUM_SLOT;
    localparam int CH_W     = 2;
    localparam int SL_W     = 2;
    localparam int ADDR_W   = 6;

    localparam int A_TOT_CE = 0;
    localparam int A_TOT_UE = 1;
    localparam int A_NI_CE  = 2;
    localparam int A_NI_UE  = 3;
    localparam int A_SEC    = 4;
    localparam int A_AGG_CE = 5;
    localparam int A_AGG_UE = A_AGG_CE + NUM_SLOT;
    localparam int A_LOC    = 16;
    localparam int A_LOC_END = A_LOC + 2 * NUM_LOC;

    typedef struct packed {
        logic            valid;
        logic            ue;
        logic            loc_ok;
        logic [CH_W-1:0] chan;
        logic [SL_W-1:0] slot;
    } err_event_t;

    function automatic logic ev_located(err_event_t e);
        return e.loc_ok && (int'(e.chan) < NUM_CHAN) && (int'(e.slot) < NUM_SLOT);
    endfunction

    function automatic int loc_index(err_event_t e);
        return int'(e.chan) * NUM_SLOT + int'(e.slot);
    endfunction

endpackage

// File: rtl/memerr_sat_cnt.sv
module memerr_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (inc && (q != MAXV))
            q <= q + 1'b1;
    end
endmodule

// File: rtl/memerr_sec_timer.sv
module memerr_sec_timer #(
    parameter int CYC_PER_SEC = 100,
    parameter int SEC_W       = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic [SEC_W-1:0] sec
);
    localparam int PS_W = (CYC_PER_SEC > 1) ? $clog2(CYC_PER_SEC) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(CYC_PER_SEC - 1);
    localparam logic [SEC_W-1:0] SEC_MAX = '1;

    logic [PS_W-1:0] ps;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ps  <= '0;
            sec <= '0;
        end else if (ps == PS_LAST) begin
            ps <= '0;
            if (sec != SEC_MAX)
                sec <= sec + 1'b1;
        end else begin
            ps <= ps + 1'b1;
        end
    end
endmodule

// File: rtl/memerr_decode.sv
module memerr_decode
    import memerr_pkg::*;
(
    input  err_event_t          ev,
    output logic [NUM_LOC-1:0]  inc_loc_ce,
    output logic [NUM_LOC-1:0]  inc_loc_ue,
    output logic [NUM_SLOT-1:0] inc_agg_ce,
    output logic [NUM_SLOT-1:0] inc_agg_ue,
    output logic                inc_tot_ce,
    output logic                inc_tot_ue,
    output logic                inc_ni_ce,
    output logic                inc_ni_ue
);
    logic located;

    always_comb begin
        located    = ev_located(ev);
        inc_loc_ce = '0;
        inc_loc_ue = '0;
        inc_agg_ce = '0;
        inc_agg_ue = '0;
        inc_tot_ce = ev.valid && !ev.ue;
        inc_tot_ue = ev.valid &&  ev.ue;
        inc_ni_ce  = ev.valid && !ev.ue && !located;
        inc_ni_ue  = ev.valid &&  ev.ue && !located;
        if (ev.valid && located) begin
            if (ev.ue) begin
                inc_loc_ue[loc_index(ev)] = 1'b1;
                inc_agg_ue[ev.slot]       = 1'b1;
            end else begin
                inc_loc_ce[loc_index(ev)] = 1'b1;
                inc_agg_ce[ev.slot]       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/memerr_read_mux.sv
module memerr_read_mux
    import memerr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SEC_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [NUM_LOC-1:0][CNT_W-1:0]  loc_ce,
    input  logic [NUM_LOC-1:0][CNT_W-1:0]  loc_ue,
    input  logic [NUM_SLOT-1:0][CNT_W-1:0] agg_ce,
    input  logic [NUM_SLOT-1:0][CNT_W-1:0] agg_ue,
    input  logic [CNT_W-1:0]               tot_ce,
    input  logic [CNT_W-1:0]               tot_ue,
    input  logic [CNT_W-1:0]               ni_ce,
    input  logic [CNT_W-1:0]               ni_ue,
    input  logic [SEC_W-1:0]               sec,
    output logic [DATA_W-1:0]              data
);
    int a;
    int li;

    always_comb begin
        a    = int'(addr);
        li   = 0;
        data = '0;
        if (a == A_TOT_CE)
            data = DATA_W'(tot_ce);
        else if (a == A_TOT_UE)
            data = DATA_W'(tot_ue);
        else if (a == A_NI_CE)
            data = DATA_W'(ni_ce);
        else if (a == A_NI_UE)
            data = DATA_W'(ni_ue);
        else if (a == A_SEC)
            data = DATA_W'(sec);
        else if (a >= A_AGG_CE && a < A_AGG_UE)
            data = DATA_W'(agg_ce[a - A_AGG_CE]);
        else if (a >= A_AGG_UE && a < A_AGG_UE + NUM_SLOT)
            data = DATA_W'(agg_ue[a - A_AGG_UE]);
        else if (a >= A_LOC && a < A_LOC_END) begin
            li = (a - A_LOC) / 2;
            if (addr[0])
                data = DATA_W'(loc_ue[li]);
            else
                data = DATA_W'(loc_ce[li]);
        end
    end
endmodule

// File: rtl/memerr_counter_bank.sv
module memerr_counter_bank
    import memerr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SEC_W       = 32,
    parameter int CYC_PER_SEC = 100000000,
    parameter int DATA_W      = (CNT_W > SEC_W) ? CNT_W : SEC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic              ev_ue,
    input  logic              ev_loc_ok,
    input  logic [CH_W-1:0]   ev_chan,
    input  logic [SL_W-1:0]   ev_slot,
    input  logic              log_ce_en,
    input  logic              log_ue_en,
    input  logic              clr_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              log_valid,
    output logic              log_ue
);
    err_event_t ev;
    assign ev = '{valid: ev_valid, ue: ev_ue, loc_ok: ev_loc_ok, chan: ev_chan, slot: ev_slot};

    logic [NUM_LOC-1:0]  inc_loc_ce, inc_loc_ue;
    logic [NUM_SLOT-1:0] inc_agg_ce, inc_agg_ue;
    logic inc_tot_ce, inc_tot_ue, inc_ni_ce, inc_ni_ue;

    memerr_decode u_dec (
        .ev(ev),
        .inc_loc_ce(inc_loc_ce), .inc_loc_ue(inc_loc_ue),
        .inc_agg_ce(inc_agg_ce), .inc_agg_ue(inc_agg_ue),
        .inc_tot_ce(inc_tot_ce), .inc_tot_ue(inc_tot_ue),
        .inc_ni_ce(inc_ni_ce),   .inc_ni_ue(inc_ni_ue)
    );

    logic [NUM_LOC-1:0][CNT_W-1:0]  loc_ce_q, loc_ue_q;
    logic [NUM_SLOT-1:0][CNT_W-1:0] agg_ce_q, agg_ue_q;
    logic [CNT_W-1:0] tot_ce_q, tot_ue_q, ni_ce_q, ni_ue_q;
    logic [SEC_W-1:0] sec_q;

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
        memerr_sat_cnt #(.W(CNT_W)) u_ce (.clk(clk), .rst(rst), .clr(clr_strobe),
                                          .inc(inc_loc_ce[g]), .q(loc_ce_q[g]));
        memerr_sat_cnt #(.W(CNT_W)) u_ue (.clk(clk), .rst(rst), .clr(clr_strobe),
                                          .inc(inc_loc_ue[g]), .q(loc_ue_q[g]));
    end

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_agg
        memerr_sat_cnt #(.W(CNT_W)) u_ce (.clk(clk), .rst(rst), .clr(clr_strobe),
                                          .inc(inc_agg_ce[s]), .q(agg_ce_q[s]));
        memerr_sat_cnt #(.W(CNT_W)) u_ue (.clk(clk), .rst(rst), .clr(clr_strobe),
                                          .inc(inc_agg_ue[s]), .q(agg_ue_q[s]));
    end

    memerr_sat_cnt #(.W(CNT_W)) u_tot_ce (.clk(clk), .rst(rst), .clr(clr_strobe),
                                          .inc(inc_tot_ce), .q(tot_ce_q));
    memerr_sat_cnt #(.W(CNT_W)) u_tot_ue (.clk(clk), .rst(rst), .clr(clr_strobe),
                                          .inc(inc_tot_ue), .q(tot_ue_q));
    memerr_sat_cnt #(.W(CNT_W)) u_ni_ce  (.clk(clk), .rst(rst), .clr(clr_strobe),
                                          .inc(inc_ni_ce), .q(ni_ce_q));
    memerr_sat_cnt #(.W(CNT_W)) u_ni_ue  (.clk(clk), .rst(rst), .clr(clr_strobe),
                                          .inc(inc_ni_ue), .q(ni_ue_q));

    memerr_sec_timer #(.CYC_PER_SEC(CYC_PER_SEC), .SEC_W(SEC_W)) u_sec (
        .clk(clk), .rst(rst), .clr(clr_strobe), .sec(sec_q)
    );

    logic [DATA_W-1:0] rd_mux;

    memerr_read_mux #(.CNT_W(CNT_W), .SEC_W(SEC_W), .DATA_W(DATA_W)) u_rd (
        .addr(rd_addr),
        .loc_ce(loc_ce_q), .loc_ue(loc_ue_q),
        .agg_ce(agg_ce_q), .agg_ue(agg_ue_q),
        .tot_ce(tot_ce_q), .tot_ue(tot_ue_q),
        .ni_ce(ni_ce_q),   .ni_ue(ni_ue_q),
        .sec(sec_q),
        .data(rd_mux)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            log_valid <= 1'b0;
            log_ue    <= 1'b0;
        end else begin
            rd_data   <= rd_mux;
            log_valid <= ev.valid && !clr_strobe && (ev.ue ? log_ue_en : log_ce_en);
            log_ue    <= ev.ue;
        end
    end
endmodule

// File: rtl/memerr_checker.sv
module memerr_checker #(
    parameter int CNT_W = 32,
    parameter int SEC_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_strobe,
    input logic             ev_valid,
    input logic             ev_ue,
    input logic             ev_loc_ok,
    input logic [1:0]       ev_chan,
    input logic [1:0]       ev_slot,
    input logic             log_ce_en,
    input logic             log_ue_en,
    input logic             log_valid,
    input logic [CNT_W-1:0] tot_ce,
    input logic [CNT_W-1:0] ni_ce,
    input logic [CNT_W-1:0] ni_ue,
    input logic [SEC_W-1:0] sec
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic unloc;
    assign unloc = !ev_loc_ok || (ev_chan > 2'd2) || (ev_slot > 2'd2);

    a_r4_clear_all: assert property (@(posedge clk) disable iff (rst)
        clr_strobe |=> (tot_ce == '0 && ni_ce == '0 && ni_ue == '0 && sec == '0));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (!clr_strobe && tot_ce == CMAX) |=> tot_ce == CMAX);

    a_r2_total_step: assert property (@(posedge clk) disable iff (rst)
        !clr_strobe |=> (tot_ce == $past(tot_ce) || tot_ce == $past(tot_ce) + 1'b1));

    a_r5_noinfo_ce: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !ev_ue && unloc && !clr_strobe && ni_ce != CMAX)
        |=> ni_ce == $past(ni_ce) + 1'b1);

    a_r5_located_no_ni: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !unloc && !clr_strobe) |=> (ni_ce == $past(ni_ce) && ni_ue == $past(ni_ue)));

    a_r6_log_source: assert property (@(posedge clk) disable iff (rst)
        log_valid |-> $past(ev_valid && !clr_strobe && (ev_ue ? log_ue_en : log_ce_en)));

    a_r8_sec_monotonic: assert property (@(posedge clk) disable iff (rst)
        !clr_strobe |=> sec >= $past(sec));
endmodule

bind memerr_counter_bank memerr_checker #(.CNT_W(CNT_W), .SEC_W(SEC_W)) u_chk (
    .clk(clk), .rst(rst), .clr_strobe(clr_strobe),
    .ev_valid(ev_valid), .ev_ue(ev_ue), .ev_loc_ok(ev_loc_ok),
    .ev_chan(ev_chan), .ev_slot(ev_slot),
    .log_ce_en(log_ce_en), .log_ue_en(log_ue_en), .log_valid(log_valid),
    .tot_ce(tot_ce_q), .ni_ce(ni_ce_q), .ni_ue(ni_ue_q), .sec(sec_q)
);

// File: tb/sim_memerr_counter_bank.sv
module sim_memerr_counter_bank;
    localparam int CW = 4;
    localparam int SW = 8;
    localparam int CPS = 10;
    localparam int DW = 8;
    localparam int MAXC = 15;

    logic clk = 0;
    logic rst = 1;
    logic ev_valid = 0, ev_ue = 0, ev_loc_ok = 0;
    logic [1:0] ev_chan = 0, ev_slot = 0;
    logic log_ce_en = 1, log_ue_en = 1, clr_strobe = 0;
    logic [5:0] rd_addr = 0;
    logic [DW-1:0] rd_data;
    logic log_valid, log_ue;

    always #5 clk = ~clk;

    memerr_counter_bank #(.CNT_W(CW), .SEC_W(SW), .CYC_PER_SEC(CPS)) u0 (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ue(ev_ue), .ev_loc_ok(ev_loc_ok),
        .ev_chan(ev_chan), .ev_slot(ev_slot), .log_ce_en(log_ce_en), .log_ue_en(log_ue_en),
        .clr_strobe(clr_strobe), .rd_addr(rd_addr), .rd_data(rd_data),
        .log_valid(log_valid), .log_ue(log_ue)
    );

    int checks = 0;
    int errors = 0;

    // stimulus: {ue, loc_ok, chan[1:0], slot[1:0]}
    localparam logic [5:0] VEC [0:19] = '{
        6'b0_1_00_00, 6'b0_1_01_01, 6'b1_1_10_10, 6'b0_1_10_00, 6'b1_1_00_00,
        6'b0_0_00_00, 6'b1_0_01_01, 6'b0_1_11_00, 6'b1_1_00_11, 6'b0_1_01_10,
        6'b0_1_00_10, 6'b1_1_01_00, 6'b0_1_10_01, 6'b0_1_10_01, 6'b1_1_10_10,
        6'b0_1_00_01, 6'b1_0_10_10, 6'b0_1_01_01, 6'b0_1_11_11, 6'b1_1_01_10
    };

    int m_lce [9], m_lue [9], m_ace [3], m_aue [3];
    int m_tce, m_tue, m_nce, m_nue;

    function automatic int sat(int v);
        return (v < MAXC) ? v + 1 : v;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 9; i++) begin m_lce[i] = 0; m_lue[i] = 0; end
        for (int i = 0; i < 3; i++) begin m_ace[i] = 0; m_aue[i] = 0; end
        m_tce = 0; m_tue = 0; m_nce = 0; m_nue = 0;
    endtask

    task automatic model_apply(logic ue, logic lok, int ch, int sl);
        if (lok && ch < 3 && sl < 3) begin
            if (ue) begin m_lue[ch*3+sl] = sat(m_lue[ch*3+sl]); m_aue[sl] = sat(m_aue[sl]); end
            else    begin m_lce[ch*3+sl] = sat(m_lce[ch*3+sl]); m_ace[sl] = sat(m_ace[sl]); end
        end else begin
            if (ue) m_nue = sat(m_nue); else m_nce = sat(m_nce);
        end
        if (ue) m_tue = sat(m_tue); else m_tce = sat(m_tce);
    endtask

    function automatic int model_at(int a);
        if (a == 0) return m_tce;
        if (a == 1) return m_tue;
        if (a == 2) return m_nce;
        if (a == 3) return m_nue;
        if (a >= 5 && a < 8) return m_ace[a-5];
        if (a >= 8 && a < 11) return m_aue[a-8];
        if (a >= 16 && a < 34) return ((a % 2) == 1) ? m_lue[(a-16)/2] : m_lce[(a-16)/2];
        return 0;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk);
        rd_addr = 6'(a);
        @(negedge clk);
        v = int'(rd_data);
    endtask

    task automatic send(logic ue, logic lok, logic [1:0] ch, logic [1:0] sl);
        @(negedge clk);
        ev_valid = 1; ev_ue = ue; ev_loc_ok = lok; ev_chan = ch; ev_slot = sl;
        @(negedge clk);
        ev_valid = 0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr_strobe = 1;
        @(negedge clk);
        clr_strobe = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 0;

        // R10 reset state
        rd(4, v); check("R10 seconds after reset", v, 0);
        rd(0, v); check("R10 ce total after reset", v, 0);
        rd(1, v); check("R10 ue total after reset", v, 0);
        rd(3, v); check("R10 ue noinfo after reset", v, 0);

        // vector table walk, logging enabled (R6 log pulse per event)
        for (int i = 0; i < 20; i++) begin
            send(VEC[i][5], VEC[i][4], VEC[i][3:2], VEC[i][1:0]);
            check("R6 log_valid when enabled", int'(log_valid), 1);
            check("R6 log_ue type", int'(log_ue), int'(VEC[i][5]));
            model_apply(VEC[i][5], VEC[i][4], int'(VEC[i][3:2]), int'(VEC[i][1:0]));
        end

        // full map compare: R1 location, R2 totals, R3 slot merge, R5 no-info, R9 unmapped
        for (int a = 0; a < 40; a++) begin
            if (a != 4) begin
                rd(a, v);
                if (a < 2) check("R2 total", v, model_at(a));
                else if (a < 4) check("R5 noinfo", v, model_at(a));
                else if (a < 11) check("R3 slot merge", v, model_at(a));
                else if (a >= 16 && a < 34) check("R1 location", v, model_at(a));
                else check("R9 unmapped reads zero", v, 0);
            end
        end

        // R7 saturation with CE logging disabled (R6 counting independent)
        pulse_clear();
        model_clear();
        log_ce_en = 0;
        for (int i = 0; i < 18; i++) begin
            send(1'b0, 1'b1, 2'd1, 2'd2);
            if (i == 0) check("R6 log_valid stays 0 when disabled", int'(log_valid), 0);
        end
        rd(26, v); check("R7 location saturates", v, MAXC);
        rd(7,  v); check("R7 slot counter saturates", v, MAXC);
        rd(0,  v); check("R7 total saturates", v, MAXC);
        rd(1,  v); check("R2 ue total untouched", v, 0);
        log_ce_en = 1;

        // R4 clear with a same-cycle event
        @(negedge clk);
        clr_strobe = 1; ev_valid = 1; ev_ue = 0; ev_loc_ok = 1; ev_chan = 2'd1; ev_slot = 2'd2;
        @(negedge clk);
        clr_strobe = 0; ev_valid = 0;
        check("R4 no log for dropped event", int'(log_valid), 0);
        for (int a = 0; a < 34; a++) begin
            if (a != 4) begin
                rd(a, v);
                check("R4 counter cleared, event dropped", v, 0);
            end
        end

        // R8 seconds step timing after clear
        @(negedge clk);
        clr_strobe = 1; rd_addr = 6'd4;
        @(negedge clk);
        clr_strobe = 0;
        repeat (10) @(negedge clk);
        check("R8 seconds before first step", int'(rd_data), 0);
        @(negedge clk);
        check("R8 seconds after first step", int'(rd_data), 1);
        repeat (13) @(negedge clk);
        check("R8 seconds after second step", int'(rd_data), 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule